// File: doc/BRIEF.md
# Ordered Priority Output Charge Distributor

This block is the switch-sequencing controller for a single-inductor converter that feeds several outputs. Each switching period begins on a period tick. The block first turns on the inductor energizing switch. When the analog current loop reports that the peak current has been reached, the block hands the stored energy to the outputs one at a time, in a fixed order from highest to lowest priority.

Every output except the lowest-priority one has a regulation comparator. Such an output keeps its select until its comparator reports that it is at or above target. The controller then moves down the order. An output whose comparator is already satisfied when its turn arrives is skipped and gets no cycles. The lowest-priority output is not gated by any comparator. It takes whatever energy is left, so the regulation error of the earlier outputs ends up there, and its external loop sets the total charge per period.

Distribution ends when the inductor-zero flag asserts. It also ends when the next period tick arrives first, which acts as a timeout. The switch enables are registered. Between any two different enables there is always at least one clock cycle with every switch off.

Top module: `ordered_charge_dist`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `charge_en` is 0 and `out_sel` is all zeros.
- R2: When idle, a `period_tick` sampled high drives `charge_en` to 1 from the next cycle. `charge_en` stays 1 until `peak_hit` is sampled high, and it is 0 in the cycle after that.
- R3: Outputs are served in index order: bit 0 of `out_sel` has the highest priority and bit NUM_OUT-1 the lowest. A gated output keeps its one-hot select while its `at_target` bit is 0. Its select drops in the cycle after that bit is sampled as 1.
- R4: A gated output whose `at_target` bit is 1 in the idle cycle before its turn is skipped. The select goes straight to the next output, in order, whose bit is 0, or else to the lowest-priority output.
- R5: The lowest-priority output has no comparator. Once selected, it stays selected whatever the value of `at_target`, until `ind_zero` or `period_tick` is sampled high.
- R6: If `ind_zero` is sampled high during distribution, meaning a select is on or the controller is in the gap before one, every output goes low in the next cycle. They stay low until a new `period_tick`. `ind_zero` has no effect during the charge phase.
- R7: `charge_en` and any `out_sel` bit are never 1 in the same cycle, and `out_sel` is one-hot or zero. Every change from one active switch to a different one passes through at least one cycle with all switches off.
- R8: A `period_tick` sampled while charging or distributing forces all outputs low in the next cycle and returns the controller to idle. That tick does not start a new charge phase. The tick takes precedence over `peak_hit`, `ind_zero` and `at_target` sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle pulse marking the start of a switching period |
| peak_hit | input | 1 | Inductor current has reached its peak target |
| ind_zero | input | 1 | Inductor current has fallen to zero |
| at_target | input | NUM_OUT-1 | Per gated output: 1 = output at or above target (bit k belongs to output k) |
| charge_en | output | 1 | Enable for the inductor energizing switch |
| out_sel | output | NUM_OUT | One-hot output select, bit 0 highest priority |

## Verification
Two pairs of events can land in the same cycle. The first is a period tick together with the peak-current flag that would close the charge phase. The bench raises both in one cycle and expects all switches off with no select appearing afterwards, because the timeout has priority and sends the controller to idle. The second is a period tick that arrives while an output is selected. Here the bench expects the select to fall one cycle later and no new charge phase to begin until a later tick.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_GAP    = 2'd2,
    ST_SERVE  = 2'd3
  } ocd_state_e;

endpackage

// File: rtl/ocd_slot_pick.sv
// Finds the first output at or after start_idx that still needs charge.
// The lowest-priority output is always eligible.
module ocd_slot_pick #(
  parameter int NUM_OUT = 4,
  parameter int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic [IDX_W-1:0]   start_idx,
  input  logic [NUM_OUT-2:0] at_target,
  output logic [IDX_W-1:0]   pick_idx
);

  localparam int LAST = NUM_OUT - 1;

  logic [NUM_OUT-1:0] eligible;

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_elig
      if (g == LAST) begin : g_last
        assign eligible[g] = (IDX_W'(g) >= start_idx);
      end else begin : g_gated
        assign eligible[g] = (IDX_W'(g) >= start_idx) && !at_target[g];
      end
    end
  endgenerate

  always_comb begin
    pick_idx = IDX_W'(LAST);
    for (int k = LAST; k >= 0; k--) begin
      if (eligible[k]) pick_idx = IDX_W'(k);
    end
  end

endmodule

// File: rtl/ocd_seq.sv
// Period sequencer: idle -> charge -> (gap -> serve)* -> idle.
module ocd_seq
  import ocd_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               period_tick,
  input  logic               peak_hit,
  input  logic               ind_zero,
  input  logic [NUM_OUT-2:0] at_target,
  input  logic [IDX_W-1:0]   pick_idx,
  output ocd_state_e         st_q,
  output ocd_state_e         st_d,
  output logic [IDX_W-1:0]   idx_q,
  output logic [IDX_W-1:0]   idx_d
);

  localparam int PAD_W = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OUT - 1);

  logic [PAD_W-1:0] ok_pad;
  logic             cur_done;

  assign ok_pad   = PAD_W'(at_target);
  assign cur_done = (idx_q != LAST_IDX) && ok_pad[idx_q];

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        if (period_tick) st_d = ST_CHARGE;
      end
      ST_CHARGE: begin
        if (period_tick) begin
          st_d = ST_IDLE;
        end else if (peak_hit) begin
          st_d  = ST_GAP;
          idx_d = '0;
        end
      end
      ST_GAP: begin
        if (period_tick || ind_zero) begin
          st_d = ST_IDLE;
        end else begin
          st_d  = ST_SERVE;
          idx_d = pick_idx;
        end
      end
      ST_SERVE: begin
        if (period_tick || ind_zero) begin
          st_d = ST_IDLE;
        end else if (cur_done) begin
          st_d  = ST_GAP;
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // R2
  tick_starts_charge_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && period_tick) |=> (st_q == ST_CHARGE));

  // R8
  tick_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && period_tick) |=> (st_q == ST_IDLE));

  // R6
  zero_ends_dist_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_GAP || st_q == ST_SERVE) && ind_zero) |=> (st_q == ST_IDLE));

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SERVE && !period_tick && !ind_zero && !cur_done)
      |=> (st_q == ST_SERVE && $stable(idx_q)));

  // R4
  order_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GAP && !period_tick && !ind_zero)
      |=> (st_q == ST_SERVE && idx_q >= $past(idx_q)));

  // R5
  last_slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SERVE && idx_q == LAST_IDX && !period_tick && !ind_zero)
      |=> (st_q == ST_SERVE && idx_q == LAST_IDX));

endmodule

// File: rtl/ocd_drive.sv
// Registered switch enables, decoded from the next state.
module ocd_drive
  import ocd_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  ocd_state_e         st_d,
  input  logic [IDX_W-1:0]   idx_d,
  output logic               charge_en_q,
  output logic [NUM_OUT-1:0] sel_q
);

  logic [NUM_OUT-1:0] sel_d;

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_dec
      assign sel_d[g] = (st_d == ST_SERVE) && (idx_d == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      charge_en_q <= 1'b0;
      sel_q       <= '0;
    end else begin
      charge_en_q <= (st_d == ST_CHARGE);
      sel_q       <= sel_d;
    end
  end

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(charge_en_q && (|sel_q)));

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));

  // R7
  sel_bbm_chk: assert property (@(posedge clk) disable iff (rst)
    (|sel_q) |=> ((sel_q == $past(sel_q)) || (sel_q == '0)));

  // R7
  sel_to_charge_chk: assert property (@(posedge clk) disable iff (rst)
    (|sel_q) |=> !charge_en_q);

  // R7
  charge_to_sel_chk: assert property (@(posedge clk) disable iff (rst)
    charge_en_q |=> (sel_q == '0));

endmodule

// File: rtl/ordered_charge_dist.sv
module ordered_charge_dist
  import ocd_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               period_tick,
  input  logic               peak_hit,
  input  logic               ind_zero,
  input  logic [NUM_OUT-2:0] at_target,
  output logic               charge_en,
  output logic [NUM_OUT-1:0] out_sel
);

  localparam int IDX_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  ocd_state_e       st_q;
  ocd_state_e       st_d;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] pick_idx;

  ocd_slot_pick #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_pick (
    .start_idx (idx_q),
    .at_target (at_target),
    .pick_idx  (pick_idx)
  );

  ocd_seq #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .period_tick (period_tick),
    .peak_hit    (peak_hit),
    .ind_zero    (ind_zero),
    .at_target   (at_target),
    .pick_idx    (pick_idx),
    .st_q        (st_q),
    .st_d        (st_d),
    .idx_q       (idx_q),
    .idx_d       (idx_d)
  );

  ocd_drive #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_drive (
    .clk         (clk),
    .rst         (rst),
    .st_d        (st_d),
    .idx_d       (idx_d),
    .charge_en_q (charge_en),
    .sel_q       (out_sel)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!charge_en && out_sel == '0));

endmodule

// File: tb/ordered_charge_dist_tb.sv
`timescale 1ns/1ps
module ordered_charge_dist_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         period_tick;
  logic         peak_hit;
  logic         ind_zero;
  logic [N-2:0] at_target;
  logic         charge_en;
  logic [N-1:0] out_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ordered_charge_dist #(.NUM_OUT(N)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .period_tick (period_tick),
    .peak_hit    (peak_hit),
    .ind_zero    (ind_zero),
    .at_target   (at_target),
    .charge_en   (charge_en),
    .out_sel     (out_sel)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_out(input logic exp_chg, input logic [N-1:0] exp_sel,
                            input string tag);
    n_checks++;
    if (charge_en !== exp_chg || out_sel !== exp_sel) begin
      n_fail++;
      $display("FAIL %s: charge_en=%b out_sel=%b expected charge_en=%b out_sel=%b",
               tag, charge_en, out_sel, exp_chg, exp_sel);
    end
  endtask

  task automatic pulse_tick();
    period_tick = 1'b1; step(); period_tick = 1'b0;
  endtask

  task automatic pulse_peak();
    peak_hit = 1'b1; step(); peak_hit = 1'b0;
  endtask

  task automatic pulse_zero();
    ind_zero = 1'b1; step(); ind_zero = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; period_tick = 0; peak_hit = 0; ind_zero = 0; at_target = '0;
    step(); step();
    expect_out(1'b0, 4'b0000, "R1 during reset");
    rst = 1'b0;
    step();
    expect_out(1'b0, 4'b0000, "R1 after release");
  endtask

  task automatic test_full_order();
    at_target = 3'b000;
    pulse_tick();
    expect_out(1'b1, 4'b0000, "R2 charge starts");
    step(); step();
    expect_out(1'b1, 4'b0000, "R2 charge held");
    pulse_peak();
    expect_out(1'b0, 4'b0000, "R7 gap after charge");
    step();
    expect_out(1'b0, 4'b0001, "R3 slot0 first");
    step(); step();
    expect_out(1'b0, 4'b0001, "R3 slot0 held");
    at_target = 3'b001; step();
    expect_out(1'b0, 4'b0000, "R7 gap after slot0");
    step();
    expect_out(1'b0, 4'b0010, "R3 slot1");
    at_target = 3'b011; step();
    expect_out(1'b0, 4'b0000, "R7 gap after slot1");
    step();
    expect_out(1'b0, 4'b0100, "R3 slot2");
    at_target = 3'b111; step(); step();
    expect_out(1'b0, 4'b1000, "R3 last slot");
    at_target = 3'b000; step(); at_target = 3'b111; step();
    expect_out(1'b0, 4'b1000, "R5 last slot ignores comparators");
    pulse_zero();
    expect_out(1'b0, 4'b0000, "R6 zero clears selects");
    step(); step();
    expect_out(1'b0, 4'b0000, "R6 waits for tick");
  endtask

  task automatic test_skip();
    at_target = 3'b101;
    pulse_tick(); pulse_peak(); step();
    expect_out(1'b0, 4'b0010, "R4 slot0 skipped");
    at_target = 3'b111; step(); step();
    expect_out(1'b0, 4'b1000, "R4 slot2 skipped");
    pulse_zero();
    expect_out(1'b0, 4'b0000, "R6 zero after skip run");
  endtask

  task automatic test_all_regulated();
    at_target = 3'b111;
    pulse_tick(); pulse_peak(); step();
    expect_out(1'b0, 4'b1000, "R5 all gated satisfied go to last");
    pulse_zero();
  endtask

  task automatic test_timeout_serve();
    at_target = 3'b000;
    pulse_tick(); pulse_peak(); step();
    expect_out(1'b0, 4'b0001, "R8 setup slot0");
    pulse_tick();
    expect_out(1'b0, 4'b0000, "R8 tick during serve clears");
    step();
    expect_out(1'b0, 4'b0000, "R8 timeout tick does not restart");
    pulse_tick();
    expect_out(1'b1, 4'b0000, "R2 next tick restarts charge");
    period_tick = 1'b1; peak_hit = 1'b1; step();
    period_tick = 1'b0; peak_hit = 1'b0;
    expect_out(1'b0, 4'b0000, "R8 tick beats peak");
    step(); step();
    expect_out(1'b0, 4'b0000, "R8 no select after tick+peak");
  endtask

  task automatic test_zero_phases();
    at_target = 3'b000;
    pulse_tick();
    pulse_zero();
    expect_out(1'b1, 4'b0000, "R6 zero ignored in charge");
    pulse_peak();
    pulse_zero();
    expect_out(1'b0, 4'b0000, "R6 zero in gap");
    step();
    expect_out(1'b0, 4'b0000, "R6 no select after zero in gap");
  endtask

  task automatic test_reset_mid();
    at_target = 3'b000;
    pulse_tick(); pulse_peak(); step();
    expect_out(1'b0, 4'b0001, "R1 setup");
    rst = 1'b1; step();
    expect_out(1'b0, 4'b0000, "R1 reset mid serve");
    rst = 1'b0; step();
    expect_out(1'b0, 4'b0000, "R1 idle after reset");
  endtask

  initial begin
    do_reset();
    test_full_order();
    test_skip();
    test_all_regulated();
    test_timeout_serve();
    test_zero_phases();
    test_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule